// File: doc/BRIEF.md
# Standby Power Sequencer

This block moves a chip between normal execution and two low-power standby states, and drives the enables that the clock and power infrastructure around it need. It also drives the held power-on reset. Hardware standby is controlled only by two active-low pins, the standby pin and the reset pin. The reset pin must go low first. The standby pin then going low powers the chip down. Raising the standby pin restarts the oscillator. Raising the reset pin afterwards resumes execution.

Software standby is entered from the running state when the software standby control bit is set and the sleep-instruction strobe pulses. Power and oscillation then stop. A rising edge on the non-maskable interrupt pin wakes the chip. The pin is first passed through a synchronizer, and its edge is only recognised while in software standby. On wake, the sequencer holds the chip in power-on reset and enables the clock to its own settling counter only. When the programmed count has elapsed, it enables the chip-wide clock and releases reset. Taking the reset pin low also ends software standby or settling.

Top module: `stby_pwr_seq`

## Requirements
- R1: After the block's own reset `por_n` is released, `mode` is 0 and `chip_clk_en`, `osc_en` and `pwr_en` are 1. `settle_clk_en` is 0, and `por_hold` equals the inverse of `rst_pin_n`.
- R2: `stby_pin_n` and `rst_pin_n` both sampled low on a clock edge puts the block in hardware standby after that edge, from any state. In hardware standby with `stby_pin_n` low, `osc_en`, `pwr_en` and `chip_clk_en` are 0 and `por_hold` is 1.
- R3: In hardware standby, `stby_pin_n` high with `rst_pin_n` low sets `osc_en` and `pwr_en` to 1. `mode` stays 3 and `chip_clk_en` stays 0.
- R4: In hardware standby, `stby_pin_n` and `rst_pin_n` both sampled high move the block to run on that edge. `por_hold` is then 0.
- R5: In run, a `sleep_stb` pulse with `stby_bit` = 1 enters software standby on that edge. There, `osc_en`, `pwr_en`, `chip_clk_en` and `settle_clk_en` are 0 and `por_hold` is 1.
- R6: In run, a `sleep_stb` pulse with `stby_bit` = 0 has no effect, and the block stays in run.
- R7: `nmi_pin` passes through SYNC_STAGES flip-flops and then a rising-edge detector. A low-to-high change applied between edges shows as `mode` = 2 after the (SYNC_STAGES+1)th following clock edge. A pin already high on entry, and edges outside software standby, do not wake the block.
- R8: While settling, `settle_clk_en` and `por_hold` are 1 and `chip_clk_en` is 0. After exactly SETTLE_CYCLES edges in settling, the block returns to run with `por_hold` 0.
- R9: The settling counter restarts from zero on every entry into software standby, so every wake takes the full SETTLE_CYCLES.
- R10: `rst_pin_n` low with `stby_pin_n` high, in software standby or settling, returns the block to run on that edge with `por_hold` 1.
- R11: `mode` encodes 0 = run, 1 = software standby, 2 = settling, 3 = hardware standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the sequencer |
| por_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| stby_pin_n | input | 1 | Hardware standby pin, active low |
| rst_pin_n | input | 1 | External reset pin, active low |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| sleep_stb | input | 1 | One-cycle strobe from the sleep instruction |
| stby_bit | input | 1 | Software standby control bit |
| osc_en | output | 1 | Oscillator enable |
| pwr_en | output | 1 | Internal power supply enable |
| chip_clk_en | output | 1 | Chip-wide clock enable |
| settle_clk_en | output | 1 | Clock enable for the settling counter alone |
| por_hold | output | 1 | Power-on reset held to the chip |
| mode | output | 2 | Current mode code |

## Verification
The mode register changes on the first clock edge after pin, strobe or control-bit stimulus. The enables and `por_hold` are combinational from that register and the live pins, so the bench drives inputs on the falling edge and compares every output half a cycle after the next rising edge. A wake arrives SYNC_STAGES+1 edges after the interrupt pin rises, and a return to run arrives SETTLE_CYCLES edges after that. Directed sequences count those edges exactly. A cycle-level model in the bench, built from the requirements, follows the random stretches edge by edge.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [1:0] {
      MODE_RUN    = 2'd0,
      MODE_SWSTBY = 2'd1,
      MODE_SETTLE = 2'd2,
      MODE_HWSTBY = 2'd3
   } mode_t;

endpackage

// File: rtl/stby_nmi_edge.sv
module stby_nmi_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic din,
   input  logic arm,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stby_nmi_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = arm & sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
   parameter int unsigned TARGET = 4096
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   output logic done
);

   localparam int unsigned CW = $clog2(TARGET + 1);

   generate
      if (TARGET < 2) begin : g_bad_target
         $error("stby_settle_cnt: TARGET must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == CW'(TARGET - 1));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
      run |-> (cnt_q <= CW'(TARGET - 1)));   // R8

endmodule

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
   import stby_pkg::*;
(
   input  logic  clk,
   input  logic  por_n,
   input  logic  stby_pin_n,
   input  logic  rst_pin_n,
   input  logic  sleep_stb,
   input  logic  stby_bit,
   input  logic  wake,
   input  logic  settle_done,
   output mode_t state
);

   mode_t nxt;
   logic  hw_req;

   assign hw_req = !rst_pin_n && !stby_pin_n;

   always_comb begin
      nxt = state;
      if (hw_req) begin
         nxt = MODE_HWSTBY;
      end else begin
         unique case (state)
            MODE_RUN:    if (sleep_stb && stby_bit) nxt = MODE_SWSTBY;
            MODE_SWSTBY: if (!rst_pin_n) nxt = MODE_RUN;
                         else if (wake) nxt = MODE_SETTLE;
            MODE_SETTLE: if (!rst_pin_n || settle_done) nxt = MODE_RUN;
            MODE_HWSTBY: if (stby_pin_n && rst_pin_n) nxt = MODE_RUN;
            default:     nxt = MODE_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) state <= MODE_RUN;
      else        state <= nxt;
   end

   AST_HW_OVERRIDE: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_pin_n && !stby_pin_n) |=> (state == MODE_HWSTBY));   // R2
   AST_HW_EXIT: assert property (@(posedge clk) disable iff (!por_n)
      (state == MODE_HWSTBY && stby_pin_n && rst_pin_n) |=> (state == MODE_RUN));   // R4
   AST_SW_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      (state == MODE_RUN && sleep_stb && stby_bit && !hw_req) |=> (state == MODE_SWSTBY));   // R5
   AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
      (state == MODE_RUN && !stby_bit && !hw_req) |=> (state == MODE_RUN));   // R6
   AST_SETTLE_FROM_SW: assert property (@(posedge clk) disable iff (!por_n)
      (state == MODE_SETTLE) |-> ($past(state) == MODE_SWSTBY || $past(state) == MODE_SETTLE));   // R7

endmodule

// File: rtl/stby_pwr_seq.sv
module stby_pwr_seq
   import stby_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 4096,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       stby_pin_n,
   input  logic       rst_pin_n,
   input  logic       nmi_pin,
   input  logic       sleep_stb,
   input  logic       stby_bit,
   output logic       osc_en,
   output logic       pwr_en,
   output logic       chip_clk_en,
   output logic       settle_clk_en,
   output logic       por_hold,
   output logic [1:0] mode
);

   mode_t state;
   logic  wake;
   logic  settle_done;
   logic  in_sw;
   logic  powered;

   assign in_sw = (state == MODE_SWSTBY);

   stby_nmi_edge #(.STAGES(SYNC_STAGES)) u_nmi (
      .clk   (clk),
      .por_n (por_n),
      .din   (nmi_pin),
      .arm   (in_sw),
      .rise  (wake)
   );

   stby_settle_cnt #(.TARGET(SETTLE_CYCLES)) u_cnt (
      .clk   (clk),
      .por_n (por_n),
      .run   (settle_clk_en),
      .done  (settle_done)
   );

   stby_mode_fsm u_fsm (
      .clk         (clk),
      .por_n       (por_n),
      .stby_pin_n  (stby_pin_n),
      .rst_pin_n   (rst_pin_n),
      .sleep_stb   (sleep_stb),
      .stby_bit    (stby_bit),
      .wake        (wake),
      .settle_done (settle_done),
      .state       (state)
   );

   assign powered       = !in_sw && !(state == MODE_HWSTBY && !stby_pin_n);
   assign osc_en        = powered;
   assign pwr_en        = powered;
   assign chip_clk_en   = (state == MODE_RUN);
   assign settle_clk_en = (state == MODE_SETTLE);
   assign por_hold      = (state != MODE_RUN) || !rst_pin_n;
   assign mode          = state;

   AST_SW_DARK: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 2'd1) |-> (!pwr_en && !osc_en && por_hold));   // R5

endmodule

// File: tb/stby_pwr_seq_bench.sv
`timescale 1ns/1ps
module stby_pwr_seq_bench;

   localparam int T = 12;
   localparam int NS = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por_n, stby_pin_n, rst_pin_n, nmi_pin, sleep_stb, stby_bit;
   logic osc_en, pwr_en, chip_clk_en, settle_clk_en, por_hold;
   logic [1:0] mode;

   stby_pwr_seq #(.SETTLE_CYCLES(T), .SYNC_STAGES(NS)) u_stby_pwr_seq (
      .clk(clk), .por_n(por_n), .stby_pin_n(stby_pin_n), .rst_pin_n(rst_pin_n),
      .nmi_pin(nmi_pin), .sleep_stb(sleep_stb), .stby_bit(stby_bit),
      .osc_en(osc_en), .pwr_en(pwr_en), .chip_clk_en(chip_clk_en),
      .settle_clk_en(settle_clk_en), .por_hold(por_hold), .mode(mode)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model: 0 run, 1 sw standby, 2 settling, 3 hw standby
   int m_st;
   int m_cnt;
   logic [NS-1:0] m_sync;
   logic m_last;

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_powered(int st, logic sp);
      return (st != 1 && !(st == 3 && !sp)) ? 1 : 0;
   endfunction

   function automatic int exp_por(int st, logic rp);
      return (st != 0 || !rp) ? 1 : 0;
   endfunction

   function automatic int next_state(int st, logic sp, logic rp, logic sl, logic sb,
                                     logic rise, logic done);
      if (!rp && !sp) return 3;
      case (st)
         0: return (sl && sb) ? 1 : 0;
         1: return !rp ? 0 : (rise ? 2 : 1);
         2: return (!rp || done) ? 0 : 2;
         default: return (sp && rp) ? 0 : 3;
      endcase
   endfunction

   task automatic model_edge();
      logic rise;
      logic done;
      int   ns;
      rise = m_sync[NS-1] && !m_last && (m_st == 1);
      done = (m_st == 2) && (m_cnt == T - 1);
      ns = next_state(m_st, stby_pin_n, rst_pin_n, sleep_stb, stby_bit, rise, done);
      m_cnt  = (m_st == 2) ? m_cnt + 1 : 0;
      m_last = m_sync[NS-1];
      m_sync = {m_sync[NS-2:0], nmi_pin};
      m_st   = ns;
   endtask

   task automatic compare(string tag);
      chk(tag, "mode", int'(mode), m_st);
      chk(tag, "osc_en", int'(osc_en), exp_powered(m_st, stby_pin_n));
      chk(tag, "pwr_en", int'(pwr_en), exp_powered(m_st, stby_pin_n));
      chk(tag, "chip_clk_en", int'(chip_clk_en), (m_st == 0) ? 1 : 0);
      chk(tag, "settle_clk_en", int'(settle_clk_en), (m_st == 2) ? 1 : 0);
      chk(tag, "por_hold", int'(por_hold), exp_por(m_st, rst_pin_n));
   endtask

   // called at a falling edge: apply inputs, take one rising edge, compare
   task automatic step(logic sp, logic rp, logic nm, logic sl, logic sb, string tag);
      stby_pin_n = sp; rst_pin_n = rp; nmi_pin = nm; sleep_stb = sl; stby_bit = sb;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int cyc;
      logic nm;
      void'($urandom(32'h5eed_1234));
      por_n = 0; stby_pin_n = 1; rst_pin_n = 1; nmi_pin = 0; sleep_stb = 0; stby_bit = 0;
      m_st = 0; m_cnt = 0; m_sync = '0; m_last = 0;
      repeat (3) @(negedge clk);
      por_n = 1;
      @(negedge clk);
      compare("R1");
      chk("R1", "por_hold follows pin", int'(por_hold), 0);

      // R6: sleep with control bit clear
      step(1, 1, 0, 1, 0, "R6");
      step(1, 1, 0, 0, 0, "R6");
      chk("R6", "mode stays run", int'(mode), 0);

      // R5: software standby entry
      step(1, 1, 0, 1, 1, "R5");
      chk("R5", "mode sw", int'(mode), 1);
      chk("R5", "pwr_en", int'(pwr_en), 0);

      // R7: wake latency through synchronizer
      cyc = 0;
      do begin step(1, 1, 1, 0, 1, "R7"); cyc++; end while (mode != 2'd2 && cyc < 20);
      chk("R7", "edges to settle", cyc, NS + 1);

      // R8: settle length
      cyc = 0;
      do begin step(1, 1, 1, 0, 1, "R8"); cyc++; end while (mode == 2'd2 && cyc < 4 * T);
      chk("R8", "settle edges", cyc, T);
      chk("R8", "por released", int'(por_hold), 0);

      // R7: pin already high on entry does not wake
      step(1, 1, 1, 1, 1, "R7");
      repeat (6) step(1, 1, 1, 0, 1, "R7");
      chk("R7", "level no wake", int'(mode), 1);

      // R9: second wake takes the full count again
      step(1, 1, 0, 0, 1, "R9");
      repeat (NS + 1) step(1, 1, 1, 0, 1, "R9");
      chk("R9", "in settle", int'(mode), 2);
      cyc = 0;
      do begin step(1, 1, 1, 0, 1, "R9"); cyc++; end while (mode == 2'd2 && cyc < 4 * T);
      chk("R9", "settle edges again", cyc, T);

      // R10: reset pin ends sw standby and settling
      step(1, 1, 0, 1, 1, "R10");
      step(1, 0, 0, 0, 1, "R10");
      chk("R10", "mode run", int'(mode), 0);
      chk("R10", "por_hold", int'(por_hold), 1);
      step(1, 1, 0, 1, 1, "R10");
      repeat (NS + 1) step(1, 1, 1, 0, 1, "R10");
      step(1, 0, 1, 0, 1, "R10");
      chk("R10", "settle aborted", int'(mode), 0);

      // R2/R3/R4: hardware standby sequence
      step(1, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, "R2");
      chk("R2", "mode hw", int'(mode), 3);
      chk("R2", "osc_en", int'(osc_en), 0);
      step(1, 0, 0, 0, 0, "R3");
      chk("R3", "osc_en", int'(osc_en), 1);
      chk("R3", "mode hw", int'(mode), 3);
      chk("R3", "chip_clk_en", int'(chip_clk_en), 0);
      step(1, 1, 0, 0, 0, "R4");
      chk("R4", "mode run", int'(mode), 0);
      chk("R4", "por_hold", int'(por_hold), 0);

      // R2: override during settling
      step(1, 1, 0, 1, 1, "R2");
      repeat (NS + 1) step(1, 1, 1, 0, 1, "R2");
      step(0, 0, 1, 0, 1, "R2");
      chk("R2", "hw from settle", int'(mode), 3);
      step(1, 1, 0, 0, 0, "R4");

      // R11: random stretches against the model
      nm = 0;
      for (int i = 0; i < 4000; i++) begin
         logic sp, rp, sl, sb;
         sp = ($urandom % 24) != 0;
         rp = ($urandom % 20) != 0;
         sl = ($urandom % 6) == 0;
         sb = $urandom % 2;
         if (($urandom % 5) == 0) nm = ~nm;
         step(sp, rp, nm, sl, sb, "R11");
      end

      finished = 1;
      finish_run();
   end

endmodule